// File: doc/BRIEF.md
# Dual-Clock Command Mailbox Pair

This block carries single command words between two ports that run on independent clocks. It sits beside a FIFO data path. Port A posts words into a forward register that port B collects. Port B posts words into a return register that port A collects. Each register has a flag owned by the posting side. The flag is active low and means "occupied". An accepted post pulls the flag low at once. A collection by the other port raises it again after the news crosses back through a synchronizer.

A port operation targets the mailbox only when its select, enable and mailbox-select inputs are all high. The write/read input then chooses between posting and collecting. While a register is occupied, further posts to it are dropped. A collected word stays in its register until the next accepted post replaces it.

Port B's output bus shows the forward register when its mailbox select is high, and the FIFO output word otherwise. Port A's output bus always shows the return register.

Top module: `dual_clock_mailbox`

## Requirements
- R1: After reset, both occupied flags are high (empty), `a_dout` is zero, and `b_dout` is zero while `b_mbx` is high.
- R2: A port performs a mailbox operation on its clock's rising edge only when its `sel`, `en` and `mbx` inputs are all 1. `wr`=1 means post and `wr`=0 means collect. Any other combination leaves both registers and both flags unchanged.
- R3: A post from port A while `a_mail1_full_n` is 1 loads `a_din` into the forward register. The flag reads 0 after that same edge. The same rule applies on port B, with `b_din`, the return register and `b_mail2_full_n`.
- R4: A post attempted while the target register's flag is 0 is ignored. The register contents are not changed.
- R5: A post becomes collectable on the reader's third rising edge after the posting edge. A collect issued before then is ignored. After an accepted collect, the writer's flag returns to 1 on the writer's second rising edge following the collect edge.
- R6: A register keeps its contents after being collected, and changes only on an accepted post.
- R7: `b_dout` equals the forward register while `b_mbx` is 1, and `b_fifo_q` while `b_mbx` is 0.
- R8: `a_dout` always equals the return register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Port A clock |
| a_rst_n | input | 1 | Port A asynchronous reset, active low |
| a_sel | input | 1 | Port A chip select, active high |
| a_wr | input | 1 | Port A direction: 1 post, 0 collect |
| a_en | input | 1 | Port A transfer enable |
| a_mbx | input | 1 | Port A mailbox select |
| a_din | input | DATA_W | Port A write data |
| a_dout | output | DATA_W | Return register contents |
| a_mail1_full_n | output | 1 | Forward register occupied flag, active low, port A domain |
| b_clk | input | 1 | Port B clock |
| b_rst_n | input | 1 | Port B asynchronous reset, active low |
| b_sel | input | 1 | Port B chip select, active high |
| b_wr | input | 1 | Port B direction: 1 post, 0 collect |
| b_en | input | 1 | Port B transfer enable |
| b_mbx | input | 1 | Port B mailbox select; also selects the output source |
| b_din | input | DATA_W | Port B write data |
| b_fifo_q | input | DATA_W | FIFO output word |
| b_dout | output | DATA_W | Forward register or FIFO word |
| b_mail2_full_n | output | 1 | Return register occupied flag, active low, port B domain |

## Verification
A wrong handshake bit shows up in one of two ways. Either a flag never recovers after a collect, or it recovers a cycle early or late against the two-edge crossing delay. The bench catches this on the next writer-side clock. A collect that the design wrongly accepts, or wrongly drops, throws the writer's flag out of step with the reference within two writer edges. A corrupted or wrongly overwritten register appears on `a_dout`, or on `b_dout` with `b_mbx` high, on the first clock after the faulty edge.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

   typedef struct packed {
      logic post;
      logic collect;
   } mbx_req_t;

   function automatic mbx_req_t decode_req(input logic sel, input logic en,
                                           input logic mbx, input logic wr);
      mbx_req_t r;
      r.post    = sel & en & mbx & wr;
      r.collect = sel & en & mbx & ~wr;
      return r;
   endfunction

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
   import mbx_pkg::*;
(
   input  logic     sel,
   input  logic     wr,
   input  logic     en,
   input  logic     mbx,
   output mbx_req_t req
);

   always_comb begin
      req = decode_req(sel, en, mbx, wr);
   end

endmodule

// File: rtl/mbx_sync.sv
module mbx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("mbx_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= 1'b0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/mbx_channel.sv
module mbx_channel #(
   parameter int DATA_W = 36,
   parameter int SYNC_STAGES = 2
) (
   input  logic              wclk,
   input  logic              wrst_n,
   input  logic              post,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] mail_q,
   output logic              full_n,
   input  logic              rclk,
   input  logic              rrst_n,
   input  logic              collect
);

   logic wtog, rtog, rtog_in_w, wtog_in_r;
   logic occupied, accept, pending, take;

   // writer domain
   assign occupied = wtog ^ rtog_in_w;
   assign accept   = post & ~occupied;
   assign full_n   = ~occupied;

   always_ff @(posedge wclk or negedge wrst_n) begin
      if (!wrst_n) begin
         wtog   <= 1'b0;
         mail_q <= '0;
      end else if (accept) begin
         wtog   <= ~wtog;
         mail_q <= wdata;
      end
   end

   mbx_sync #(.STAGES(SYNC_STAGES)) u_sync_r2w (
      .clk(wclk), .rst_n(wrst_n), .d(rtog), .q(rtog_in_w)
   );

   // reader domain
   assign pending = wtog_in_r ^ rtog;
   assign take    = collect & pending;

   always_ff @(posedge rclk or negedge rrst_n) begin
      if (!rrst_n)   rtog <= 1'b0;
      else if (take) rtog <= ~rtog;
   end

   mbx_sync #(.STAGES(SYNC_STAGES)) u_sync_w2r (
      .clk(rclk), .rst_n(rrst_n), .d(wtog), .q(wtog_in_r)
   );

endmodule

// File: rtl/dual_clock_mailbox.sv
module dual_clock_mailbox
   import mbx_pkg::*;
#(
   parameter int DATA_W = 36,
   parameter int SYNC_STAGES = 2
) (
   input  logic              a_clk,
   input  logic              a_rst_n,
   input  logic              a_sel,
   input  logic              a_wr,
   input  logic              a_en,
   input  logic              a_mbx,
   input  logic [DATA_W-1:0] a_din,
   output logic [DATA_W-1:0] a_dout,
   output logic              a_mail1_full_n,
   input  logic              b_clk,
   input  logic              b_rst_n,
   input  logic              b_sel,
   input  logic              b_wr,
   input  logic              b_en,
   input  logic              b_mbx,
   input  logic [DATA_W-1:0] b_din,
   input  logic [DATA_W-1:0] b_fifo_q,
   output logic [DATA_W-1:0] b_dout,
   output logic              b_mail2_full_n
);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be positive");
      end
   endgenerate

   mbx_req_t          a_req, b_req;
   logic [DATA_W-1:0] mail1_q, mail2_q;

   mbx_port_decode u_dec_a (
      .sel(a_sel), .wr(a_wr), .en(a_en), .mbx(a_mbx), .req(a_req)
   );
   mbx_port_decode u_dec_b (
      .sel(b_sel), .wr(b_wr), .en(b_en), .mbx(b_mbx), .req(b_req)
   );

   // forward: A posts, B collects
   mbx_channel #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_fwd (
      .wclk(a_clk), .wrst_n(a_rst_n), .post(a_req.post), .wdata(a_din),
      .mail_q(mail1_q), .full_n(a_mail1_full_n),
      .rclk(b_clk), .rrst_n(b_rst_n), .collect(b_req.collect)
   );

   // return: B posts, A collects
   mbx_channel #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ret (
      .wclk(b_clk), .wrst_n(b_rst_n), .post(b_req.post), .wdata(b_din),
      .mail_q(mail2_q), .full_n(b_mail2_full_n),
      .rclk(a_clk), .rrst_n(a_rst_n), .collect(a_req.collect)
   );

   assign a_dout = mail2_q;
   assign b_dout = b_mbx ? mail1_q : b_fifo_q;

endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
   parameter int DATA_W = 36
) (
   input logic              a_clk,
   input logic              a_rst_n,
   input logic              a_sel,
   input logic              a_wr,
   input logic              a_en,
   input logic              a_mbx,
   input logic [DATA_W-1:0] a_dout,
   input logic              a_mail1_full_n,
   input logic              b_clk,
   input logic              b_rst_n,
   input logic              b_sel,
   input logic              b_wr,
   input logic              b_en,
   input logic              b_mbx,
   input logic [DATA_W-1:0] b_fifo_q,
   input logic [DATA_W-1:0] b_dout,
   input logic              b_mail2_full_n,
   input logic [DATA_W-1:0] mail1_q,
   input logic [DATA_W-1:0] mail2_q
);

   logic a_post, b_post;
   assign a_post = a_sel & a_en & a_mbx & a_wr;
   assign b_post = b_sel & b_en & b_mbx & b_wr;

   assert_fwd_post_locks_R3: assert property (@(posedge a_clk) disable iff (!a_rst_n)
      (a_post && a_mail1_full_n) |=> !a_mail1_full_n);
   assert_ret_post_locks_R3: assert property (@(posedge b_clk) disable iff (!b_rst_n)
      (b_post && b_mail2_full_n) |=> !b_mail2_full_n);

   assert_fwd_blocked_R4: assert property (@(posedge a_clk) disable iff (!a_rst_n)
      (a_post && !a_mail1_full_n) |=> $stable(mail1_q));
   assert_ret_blocked_R4: assert property (@(posedge b_clk) disable iff (!b_rst_n)
      (b_post && !b_mail2_full_n) |=> $stable(mail2_q));

   assert_fwd_hold_R6: assert property (@(posedge a_clk) disable iff (!a_rst_n)
      !a_post |=> $stable(mail1_q));
   assert_ret_hold_R6: assert property (@(posedge b_clk) disable iff (!b_rst_n)
      !b_post |=> $stable(mail2_q));

   assert_bdout_mail_R7: assert property (@(posedge b_clk) disable iff (!b_rst_n)
      b_mbx |-> (b_dout == mail1_q));
   assert_bdout_fifo_R7: assert property (@(posedge b_clk) disable iff (!b_rst_n)
      !b_mbx |-> (b_dout == b_fifo_q));
   assert_adout_R8: assert property (@(posedge a_clk) disable iff (!a_rst_n)
      a_dout == mail2_q);

endmodule

bind dual_clock_mailbox mbx_checker #(.DATA_W(DATA_W)) i_chk (
   .a_clk(a_clk), .a_rst_n(a_rst_n), .a_sel(a_sel), .a_wr(a_wr), .a_en(a_en),
   .a_mbx(a_mbx), .a_dout(a_dout), .a_mail1_full_n(a_mail1_full_n),
   .b_clk(b_clk), .b_rst_n(b_rst_n), .b_sel(b_sel), .b_wr(b_wr), .b_en(b_en),
   .b_mbx(b_mbx), .b_fifo_q(b_fifo_q), .b_dout(b_dout),
   .b_mail2_full_n(b_mail2_full_n), .mail1_q(mail1_q), .mail2_q(mail2_q)
);

// File: tb/test_dual_clock_mailbox.sv
`timescale 1ns/1ps
module test_dual_clock_mailbox;
   localparam int W = 36;

   logic a_clk = 1'b0, b_clk = 1'b0;
   logic a_rst_n = 1'b0, b_rst_n = 1'b0;
   logic a_sel = 0, a_wr = 0, a_en = 0, a_mbx = 0;
   logic b_sel = 0, b_wr = 0, b_en = 0, b_mbx = 0;
   logic [W-1:0] a_din = '0, b_din = '0, b_fifo_q = '0;
   logic [W-1:0] a_dout, b_dout;
   logic a_mail1_full_n, b_mail2_full_n;

   always #4    a_clk = ~a_clk;   // 125 MHz
   always #6.85 b_clk = ~b_clk;

   dual_clock_mailbox #(.DATA_W(W)) i_dual_clock_mailbox (.*);

   int checks = 0, failures = 0;
   bit live = 0;

   task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                      input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference: event counts per register and their delayed views
   int m_wr1, m_rd1, m_rd1_a1, m_rd1_a2, m_wr1_b1, m_wr1_b2;
   int m_wr2, m_rd2, m_rd2_b1, m_rd2_b2, m_wr2_a1, m_wr2_a2;
   logic [W-1:0] m_mail1, m_mail2;

   always @(posedge a_clk or negedge a_rst_n) begin
      if (!a_rst_n) begin
         m_wr1 <= 0; m_rd1_a1 <= 0; m_rd1_a2 <= 0; m_mail1 <= '0;
         m_rd2 <= 0; m_wr2_a1 <= 0; m_wr2_a2 <= 0;
      end else begin
         m_rd1_a1 <= m_rd1; m_rd1_a2 <= m_rd1_a1;
         m_wr2_a1 <= m_wr2; m_wr2_a2 <= m_wr2_a1;
         if (a_sel && a_en && a_mbx && a_wr && m_wr1 == m_rd1_a2) begin
            m_wr1 <= m_wr1 + 1; m_mail1 <= a_din;
         end
         if (a_sel && a_en && a_mbx && !a_wr && m_wr2_a2 != m_rd2)
            m_rd2 <= m_rd2 + 1;
      end
   end

   always @(posedge b_clk or negedge b_rst_n) begin
      if (!b_rst_n) begin
         m_wr2 <= 0; m_rd2_b1 <= 0; m_rd2_b2 <= 0; m_mail2 <= '0;
         m_rd1 <= 0; m_wr1_b1 <= 0; m_wr1_b2 <= 0;
      end else begin
         m_rd2_b1 <= m_rd2; m_rd2_b2 <= m_rd2_b1;
         m_wr1_b1 <= m_wr1; m_wr1_b2 <= m_wr1_b1;
         if (b_sel && b_en && b_mbx && b_wr && m_wr2 == m_rd2_b2) begin
            m_wr2 <= m_wr2 + 1; m_mail2 <= b_din;
         end
         if (b_sel && b_en && b_mbx && !b_wr && m_wr1_b2 != m_rd1)
            m_rd1 <= m_rd1 + 1;
      end
   end

   // per-clock comparison against the reference
   always @(negedge a_clk) if (live) begin
      chk(a_mail1_full_n == (m_wr1 == m_rd1_a2), "R3/R5 forward flag",
          W'(a_mail1_full_n), W'(m_wr1 == m_rd1_a2));
      chk(a_dout == m_mail2, "R8 a_dout", a_dout, m_mail2);
   end
   always @(negedge b_clk) if (live) begin
      chk(b_mail2_full_n == (m_wr2 == m_rd2_b2), "R3/R5 return flag",
          W'(b_mail2_full_n), W'(m_wr2 == m_rd2_b2));
      chk(b_dout == (b_mbx ? m_mail1 : b_fifo_q), "R7 b_dout", b_dout,
          b_mbx ? m_mail1 : b_fifo_q);
   end

   task automatic a_op(input bit sel, input bit wr, input bit en, input bit mbx,
                       input logic [W-1:0] d);
      @(posedge a_clk); #1;
      a_sel = sel; a_wr = wr; a_en = en; a_mbx = mbx; a_din = d;
      @(posedge a_clk); #1;
      a_sel = 0; a_en = 0; a_mbx = 0;
   endtask
   task automatic b_op(input bit sel, input bit wr, input bit en, input bit mbx,
                       input logic [W-1:0] d);
      @(posedge b_clk); #1;
      b_sel = sel; b_wr = wr; b_en = en; b_mbx = mbx; b_din = d;
      @(posedge b_clk); #1;
      b_sel = 0; b_en = 0; b_mbx = 0;
   endtask
   task automatic a_wait(input int n);
      repeat (n) @(posedge a_clk);
      @(negedge a_clk);
   endtask
   task automatic b_wait(input int n);
      repeat (n) @(posedge b_clk);
      @(negedge b_clk);
   endtask

   initial begin : watchdog
      #1500000;
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      b_fifo_q = 36'h5A5A5A5A5;
      #30; a_rst_n = 1; b_rst_n = 1;
      @(negedge b_clk); b_mbx = 1; #0.1;
      chk(a_mail1_full_n && b_mail2_full_n, "R1 flags after reset",
          W'({a_mail1_full_n, b_mail2_full_n}), W'(2'b11));
      chk(a_dout == '0, "R1 a_dout after reset", a_dout, '0);
      chk(b_dout == '0, "R1 mail1 after reset", b_dout, '0);
      b_mbx = 0;
      live = 1;

      // R2: incomplete selects do nothing
      a_op(1, 1, 0, 1, 36'h111111111);
      a_op(0, 1, 1, 1, 36'h222222222);
      a_op(1, 1, 1, 0, 36'h333333333);
      a_wait(1);
      chk(a_mail1_full_n == 1'b1, "R2 forward flag after non-mailbox ops",
          W'(a_mail1_full_n), W'(1));

      // R3: accepted post
      a_op(1, 1, 1, 1, 36'hABCDE0123);
      chk(a_mail1_full_n == 1'b0, "R3 forward flag after post", W'(a_mail1_full_n), W'(0));
      // R4: second post dropped
      a_op(1, 1, 1, 1, 36'h0DEADBEEF);
      b_wait(4);
      b_mbx = 1; #0.1;
      chk(b_dout == 36'hABCDE0123, "R4 forward word kept", b_dout, 36'hABCDE0123);
      b_mbx = 0;
      // R5: collect and flag return
      b_op(1, 0, 1, 1, '0);
      a_wait(3);
      chk(a_mail1_full_n == 1'b1, "R5 forward flag back high", W'(a_mail1_full_n), W'(1));
      // R6: contents persist after collect
      @(negedge b_clk); b_mbx = 1; #0.1;
      chk(b_dout == 36'hABCDE0123, "R6 forward word after collect", b_dout, 36'hABCDE0123);
      b_mbx = 0; #0.1;
      chk(b_dout == b_fifo_q, "R7 fifo word when mbx low", b_dout, b_fifo_q);

      // return direction
      b_op(1, 1, 1, 1, 36'h876543210);
      chk(b_mail2_full_n == 1'b0, "R3 return flag after post", W'(b_mail2_full_n), W'(0));
      b_op(1, 1, 1, 1, 36'hFFFFFFFFF);
      a_wait(1);
      chk(a_dout == 36'h876543210, "R4 R8 return word kept", a_dout, 36'h876543210);
      a_op(1, 0, 1, 1, '0);
      b_wait(3);
      chk(b_mail2_full_n == 1'b1, "R5 return flag back high", W'(b_mail2_full_n), W'(1));
      chk(a_dout == 36'h876543210, "R6 return word after collect", a_dout, 36'h876543210);

      // R5: collect issued before the post is visible is dropped
      @(posedge b_clk); #1;
      b_sel = 1; b_en = 1; b_mbx = 1; b_wr = 1; b_din = 36'h13579BDF0;
      @(posedge b_clk); #1;
      b_sel = 0; b_en = 0; b_mbx = 0;
      fork
         a_op(1, 0, 1, 1, '0);
      join
      b_wait(4);
      chk(b_mail2_full_n == (m_wr2 == m_rd2_b2), "R5 early collect outcome",
          W'(b_mail2_full_n), W'(m_wr2 == m_rd2_b2));

      // mixed traffic on both ports, compared every clock
      fork
         for (int i = 0; i < 4000; i++) begin
            @(posedge a_clk); #1;
            a_sel = $urandom_range(0, 7) != 0; a_en = $urandom_range(0, 3) != 0;
            a_mbx = $urandom_range(0, 2) != 0; a_wr = $urandom_range(0, 1);
            a_din = {$urandom, $urandom} & {W{1'b1}};
         end
         for (int j = 0; j < 2400; j++) begin
            @(posedge b_clk); #1;
            b_sel = $urandom_range(0, 7) != 0; b_en = $urandom_range(0, 3) != 0;
            b_mbx = $urandom_range(0, 2) != 0; b_wr = $urandom_range(0, 1);
            b_din = {$urandom, $urandom} & {W{1'b1}};
            b_fifo_q = {$urandom, $urandom} & {W{1'b1}};
         end
      join
      a_sel = 0; b_sel = 0;
      a_wait(4);
      live = 0;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule